// File: doc/BRIEF.md
# Jump Target and Link Unit

This block works out where control goes next, and what gets written back, for the unconditional jump operations and the PC-relative upper-immediate add of a 32-bit RISC-style core. It takes the current program counter, the first source register value, a 2-bit operation code, the immediates already pulled out of the instruction word, the destination register index and a flag that marks a 16-bit instruction. It returns a redirect flag with the new PC, and a register write-enable with the value to write.

There are three address formulas:
- The PC-relative jump adds a signed offset, counted in halfwords, to the PC.
- The register-indirect jump adds a signed 12-bit offset to the register value and then clears bit 0 of the sum.
- The upper-immediate add places a 20-bit field above twelve zero bits and adds it to the PC, without redirecting.

Targets only need to be halfword aligned, so compressed code is supported. The link value is the address of the next instruction. All results leave through one register stage with a synchronous active-high reset.

Top module: `jump_target_unit`

## Requirements
- R1: While `rst` is high at a rising edge, all four outputs become zero on that edge.
- R2: With `op_i` = 1 (PC-relative jump), `target_o` = `pc_i` + sign-extended `jal_off_i` × 2. Bit 1 of the result is kept as computed, and `redirect_o` is 1.
- R3: With `op_i` = 2 (register-indirect jump), `target_o` = (`rs1_i` + sign-extended `jalr_off_i`) with bit 0 cleared after the add, and `redirect_o` is 1. A zero offset yields `rs1_i` with bit 0 cleared.
- R4: With `op_i` = 3 (upper-immediate add), `wr_data_o` = `pc_i` + (`upper_imm_i` << 12), while `redirect_o` = 0 and `target_o` = 0.
- R5: For both jumps, `wr_data_o` is `pc_i` + 2 when `short_i` is 1 and `pc_i` + 4 when `short_i` is 0.
- R6: When `rd_i` is 0, `wr_en_o` is 0 and `wr_data_o` is 0 for every operation. For codes 1, 2 and 3 with a nonzero `rd_i`, `wr_en_o` is 1.
- R7: Every addition wraps modulo 2^32 with no overflow indication.
- R8: With `op_i` = 0 (no operation), all four outputs are zero whatever the other inputs hold.
- R9: Outputs reflect the inputs sampled at the previous rising edge: one cycle of latency, and no change between edges.
- R10: An upper-immediate add whose result is fed as `rs1_i` to a register-indirect jump reaches `pc` + D for any even 32-bit displacement D. The upper field is (D + 0x800) >> 12 and the low field is the remaining signed 12 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 2 | 0 none, 1 PC-relative jump, 2 register-indirect jump, 3 upper-immediate add |
| pc_i | input | 32 | PC of the current instruction |
| rs1_i | input | 32 | First source register value |
| jal_off_i | input | 20 | Signed halfword offset for the PC-relative jump |
| jalr_off_i | input | 12 | Signed byte offset for the register-indirect jump |
| upper_imm_i | input | 20 | Upper-immediate field |
| rd_i | input | 5 | Destination register index |
| short_i | input | 1 | 1 when the instruction is 16 bits long |
| redirect_o | output | 1 | PC redirect request |
| target_o | output | 32 | Redirect target, zero when no redirect |
| wr_en_o | output | 1 | Register write enable |
| wr_data_o | output | 32 | Link value or upper-immediate sum, zero when not writing |

## Verification
Each jump kind is driven with a positive offset, a negative offset, and the largest and smallest encodable offsets. These patterns catch a wrong sign-extension width and a lost halfword shift. A register-indirect case with an odd base and an odd offset separates clearing bit 0 after the add from clearing it before, and a PC-relative case with a result whose bit 1 is set catches wrongly forced word alignment. Sums that cross 2^32 and link values of PC+2 against PC+4 test wrap-around and length handling. Finally, pairs of an upper-immediate add followed by a register-indirect jump, with low parts both above and below 0x800, confirm that the rounding into the upper field reaches the intended target.

// File: rtl/jtu_pkg.sv
package jtu_pkg;

  typedef enum logic [1:0] {
    JTU_NONE  = 2'd0,
    JTU_JAL   = 2'd1,
    JTU_JALR  = 2'd2,
    JTU_AUIPC = 2'd3
  } jtu_op_e;

  localparam int unsigned JTU_OP_W = 2;

endpackage

// File: rtl/jtu_target_calc.sv
// Redirect target for the two jump kinds.
module jtu_target_calc
  import jtu_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned JOFF_W = 20,
  parameter int unsigned IOFF_W = 12
) (
  input  jtu_op_e           op,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   rs1,
  input  logic [JOFF_W-1:0] joff,
  input  logic [IOFF_W-1:0] ioff,
  output logic              redirect,
  output logic [XLEN-1:0]   target
);

  localparam int unsigned JEXT = XLEN - JOFF_W - 1;
  localparam int unsigned IEXT = XLEN - IOFF_W;

  logic [XLEN-1:0] joff_x;
  logic [XLEN-1:0] ioff_x;
  logic [XLEN-1:0] rel_sum;
  logic [XLEN-1:0] ind_sum;

  // halfword offset: implicit zero LSB, bit 1 left as computed
  assign joff_x  = {{JEXT{joff[JOFF_W-1]}}, joff, 1'b0};
  assign ioff_x  = {{IEXT{ioff[IOFF_W-1]}}, ioff};
  assign rel_sum = pc + joff_x;
  assign ind_sum = rs1 + ioff_x;

  always_comb begin
    redirect = 1'b0;
    target   = '0;
    unique case (op)
      JTU_JAL: begin
        redirect = 1'b1;
        target   = rel_sum;
      end
      JTU_JALR: begin
        redirect = 1'b1;
        target   = {ind_sum[XLEN-1:1], 1'b0};
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/jtu_wb_calc.sv
// Write-back value: link address or upper-immediate sum.
module jtu_wb_calc
  import jtu_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned UIMM_W = 20,
  parameter int unsigned RIDX_W = 5
) (
  input  jtu_op_e           op,
  input  logic [XLEN-1:0]   pc,
  input  logic [UIMM_W-1:0] uimm,
  input  logic [RIDX_W-1:0] rd,
  input  logic              is_short,
  output logic              wr_en,
  output logic [XLEN-1:0]   wr_data
);

  localparam int unsigned LOW_ZEROS = XLEN - UIMM_W;

  logic [XLEN-1:0] step;
  logic [XLEN-1:0] link;
  logic [XLEN-1:0] upper_x;
  logic [XLEN-1:0] upper_sum;
  logic            rd_live;

  assign step      = is_short ? XLEN'(2) : XLEN'(4);
  assign link      = pc + step;
  assign upper_x   = {uimm, {LOW_ZEROS{1'b0}}};
  assign upper_sum = pc + upper_x;
  assign rd_live   = |rd;

  always_comb begin
    wr_en   = 1'b0;
    wr_data = '0;
    if (rd_live) begin
      unique case (op)
        JTU_JAL, JTU_JALR: begin
          wr_en   = 1'b1;
          wr_data = link;
        end
        JTU_AUIPC: begin
          wr_en   = 1'b1;
          wr_data = upper_sum;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/jtu_out_stage.sv
// Optional output register with synchronous reset.
module jtu_out_stage #(
  parameter int unsigned W      = 66,
  parameter bit          REGOUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (REGOUT) begin : g_reg
      logic [W-1:0] q_r;
      always_ff @(posedge clk) begin
        if (rst) q_r <= '0;
        else     q_r <= d;
      end
      assign q = q_r;
    end else begin : g_thru
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/jump_target_unit.sv
module jump_target_unit
  import jtu_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned JOFF_W = 20,
  parameter int unsigned IOFF_W = 12,
  parameter int unsigned UIMM_W = 20,
  parameter int unsigned RIDX_W = 5,
  parameter bit          REGOUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        op_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   rs1_i,
  input  logic [JOFF_W-1:0] jal_off_i,
  input  logic [IOFF_W-1:0] jalr_off_i,
  input  logic [UIMM_W-1:0] upper_imm_i,
  input  logic [RIDX_W-1:0] rd_i,
  input  logic              short_i,
  output logic              redirect_o,
  output logic [XLEN-1:0]   target_o,
  output logic              wr_en_o,
  output logic [XLEN-1:0]   wr_data_o
);

  localparam int unsigned PACK_W = 2 * XLEN + 2;

  jtu_op_e         op;
  logic            redir_c;
  logic [XLEN-1:0] tgt_c;
  logic            we_c;
  logic [XLEN-1:0] wd_c;
  logic [PACK_W-1:0] pack_d;
  logic [PACK_W-1:0] pack_q;

  assign op = jtu_op_e'(op_i);

  jtu_target_calc #(
    .XLEN(XLEN), .JOFF_W(JOFF_W), .IOFF_W(IOFF_W)
  ) u_tgt (
    .op(op), .pc(pc_i), .rs1(rs1_i), .joff(jal_off_i), .ioff(jalr_off_i),
    .redirect(redir_c), .target(tgt_c)
  );

  jtu_wb_calc #(
    .XLEN(XLEN), .UIMM_W(UIMM_W), .RIDX_W(RIDX_W)
  ) u_wb (
    .op(op), .pc(pc_i), .uimm(upper_imm_i), .rd(rd_i), .is_short(short_i),
    .wr_en(we_c), .wr_data(wd_c)
  );

  assign pack_d = {redir_c, tgt_c, we_c, wd_c};

  jtu_out_stage #(.W(PACK_W), .REGOUT(REGOUT)) u_out (
    .clk(clk), .rst(rst), .d(pack_d), .q(pack_q)
  );

  assign redirect_o = pack_q[PACK_W-1];
  assign target_o   = pack_q[PACK_W-2 -: XLEN];
  assign wr_en_o    = pack_q[XLEN];
  assign wr_data_o  = pack_q[XLEN-1:0];

  generate
    if (REGOUT) begin : g_chk
      // R6: the zero register is never written
      a_r6_no_x0_write: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(rd_i) == '0) |-> (!wr_en_o && wr_data_o == '0));

      // R3: indirect target always has bit 0 clear
      a_r3_jalr_even: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_i) == 2'd2) |-> (redirect_o && !target_o[0]));

      // R4: upper-immediate add keeps PC low bits and never redirects
      a_r4_auipc_low_bits: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_i) == 2'd3)
          |-> (!redirect_o && target_o == '0 &&
               (!wr_en_o || wr_data_o[XLEN-UIMM_W-1:0] == $past(pc_i[XLEN-UIMM_W-1:0]))));

      // R8: no-op produces nothing
      a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_i) == 2'd0) |-> (!redirect_o && !wr_en_o));

      // R5: link value is the next instruction address
      a_r5_link_step: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_i[0] ^ op_i[1]) && wr_en_o)
          |-> (wr_data_o == $past(pc_i) + ($past(short_i) ? XLEN'(2) : XLEN'(4))));

      // R9: outputs change only from inputs registered at an edge
      a_r9_redirect_src: assert property (@(posedge clk) disable iff (rst)
        redirect_o |-> ($past(op_i) == 2'd1 || $past(op_i) == 2'd2));
    end
  endgenerate

endmodule

// File: tb/jump_target_unit_tb.sv
`timescale 1ns/1ps
module jump_target_unit_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  op_i;
  logic [31:0] pc_i, rs1_i;
  logic [19:0] jal_off_i, upper_imm_i;
  logic [11:0] jalr_off_i;
  logic [4:0]  rd_i;
  logic        short_i;
  logic        redirect_o, wr_en_o;
  logic [31:0] target_o, wr_data_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  jump_target_unit u_dut (
    .clk(clk), .rst(rst), .op_i(op_i), .pc_i(pc_i), .rs1_i(rs1_i),
    .jal_off_i(jal_off_i), .jalr_off_i(jalr_off_i), .upper_imm_i(upper_imm_i),
    .rd_i(rd_i), .short_i(short_i), .redirect_o(redirect_o), .target_o(target_o),
    .wr_en_o(wr_en_o), .wr_data_o(wr_data_o)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [1:0]  op;
    logic [31:0] pc;
    logic [31:0] rs1;
    logic [19:0] joff;
    logic [11:0] ioff;
    logic [19:0] uimm;
    logic [4:0]  rd;
    logic        sh;
    logic        e_redir;
    logic [31:0] e_tgt;
    logic        e_we;
    logic [31:0] e_wd;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    // R2 forward jump, 32-bit link
    '{8'd2, 2'd1, 32'h0000_1000, 32'h0, 20'h00010, 12'h0, 20'h0, 5'd1, 1'b0, 1'b1, 32'h0000_1020, 1'b1, 32'h0000_1004},
    // R2 backward jump, bit 1 of target set; R5 short link
    '{8'd2, 2'd1, 32'h0000_2000, 32'h0, 20'hFFFFF, 12'h0, 20'h0, 5'd5, 1'b1, 1'b1, 32'h0000_1FFE, 1'b1, 32'h0000_2002},
    // R6 largest positive offset, rd = 0
    '{8'd6, 2'd1, 32'h0010_0000, 32'h0, 20'h7FFFF, 12'h0, 20'h0, 5'd0, 1'b0, 1'b1, 32'h001F_FFFE, 1'b0, 32'h0},
    // R2 most negative offset
    '{8'd2, 2'd1, 32'h0010_0000, 32'h0, 20'h80000, 12'h0, 20'h0, 5'd1, 1'b0, 1'b1, 32'h0000_0000, 1'b1, 32'h0010_0004},
    // R3 plain return: zero offset, rd = 0
    '{8'd3, 2'd2, 32'h0000_0300, 32'h0000_4000, 20'h0, 12'h000, 20'h0, 5'd0, 1'b0, 1'b1, 32'h0000_4000, 1'b0, 32'h0},
    // R3 mask after add: odd base + odd offset
    '{8'd3, 2'd2, 32'h0000_0500, 32'h0000_1001, 20'h0, 12'h001, 20'h0, 5'd1, 1'b1, 1'b1, 32'h0000_1002, 1'b1, 32'h0000_0502},
    // R3 most negative offset
    '{8'd3, 2'd2, 32'h0000_0600, 32'h0000_1000, 20'h0, 12'h800, 20'h0, 5'd31, 1'b0, 1'b1, 32'h0000_0800, 1'b1, 32'h0000_0604},
    // R7 target and link both wrap
    '{8'd7, 2'd2, 32'hFFFF_FFFC, 32'hFFFF_FFF0, 20'h0, 12'h020, 20'h0, 5'd2, 1'b0, 1'b1, 32'h0000_0010, 1'b1, 32'h0000_0000},
    // R4 upper-immediate add
    '{8'd4, 2'd3, 32'h0000_1234, 32'h0, 20'h0, 12'h0, 20'h12345, 5'd7, 1'b0, 1'b0, 32'h0, 1'b1, 32'h1234_6234},
    // R7 upper-immediate add wraps
    '{8'd7, 2'd3, 32'hF000_0000, 32'h0, 20'h0, 12'h0, 20'h20000, 5'd3, 1'b1, 1'b0, 32'h0, 1'b1, 32'h1000_0000},
    // R6 upper-immediate add to x0
    '{8'd6, 2'd3, 32'h0000_1234, 32'h0, 20'h0, 12'h0, 20'h12345, 5'd0, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0},
    // R8 no-op with busy inputs
    '{8'd8, 2'd0, 32'hDEAD_BEEE, 32'h1234_5679, 20'h7FFFF, 12'hFFF, 20'hFFFFF, 5'd9, 1'b1, 1'b0, 32'h0, 1'b0, 32'h0},
    // R7 forward jump wraps past 2^32
    '{8'd7, 2'd1, 32'hFFFF_FFF0, 32'h0, 20'h00010, 12'h0, 20'h0, 5'd1, 1'b1, 1'b1, 32'h0000_0010, 1'b1, 32'hFFFF_FFF2}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [31:0] pc, input logic [31:0] rs1,
                       input logic [19:0] joff, input logic [11:0] ioff, input logic [19:0] uimm,
                       input logic [4:0] rd, input logic sh);
    @(negedge clk);
    op_i = op; pc_i = pc; rs1_i = rs1; jal_off_i = joff;
    jalr_off_i = ioff; upper_imm_i = uimm; rd_i = rd; short_i = sh;
    @(posedge clk);
    #1;
  endtask

  task automatic far_pair(input logic [31:0] pc, input logic [31:0] disp);
    logic [31:0] hi;
    logic [31:0] base;
    hi = (disp + 32'h800) >> 12;
    drive(2'd3, pc, 32'h0, 20'h0, 12'h0, hi[19:0], 5'd6, 1'b0);
    base = wr_data_o;
    drive(2'd2, pc + 32'd4, base, 20'h0, disp[11:0], 20'h0, 5'd0, 1'b0);
    // R10 pair reaches pc + disp
    check("R10 far target", target_o, pc + disp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    op_i = 2'd1; pc_i = 32'h100; rs1_i = 32'h0; jal_off_i = 20'h10;
    jalr_off_i = 12'h0; upper_imm_i = 20'h0; rd_i = 5'd1; short_i = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset holds outputs at zero even with a jump presented
    check("R1 redirect", {31'h0, redirect_o}, 32'h0);
    check("R1 target", target_o, 32'h0);
    check("R1 wr_en", {31'h0, wr_en_o}, 32'h0);
    check("R1 wr_data", wr_data_o, 32'h0);
    @(negedge clk);
    rst = 1'b0; op_i = 2'd0;
    @(posedge clk);
    #1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tag;
      v = VECS[i];
      tag = $sformatf("R%0d vec%0d", v.req, i);
      drive(v.op, v.pc, v.rs1, v.joff, v.ioff, v.uimm, v.rd, v.sh);
      check({tag, " redirect"}, {31'h0, redirect_o}, {31'h0, v.e_redir});
      check({tag, " target"}, target_o, v.e_tgt);
      check({tag, " wr_en"}, {31'h0, wr_en_o}, {31'h0, v.e_we});
      check({tag, " wr_data"}, wr_data_o, v.e_wd);
    end

    // R9 latency: new inputs do not show before the next edge
    drive(2'd0, 32'h0, 32'h0, 20'h0, 12'h0, 20'h0, 5'd0, 1'b0);
    @(negedge clk);
    op_i = 2'd1; pc_i = 32'h0000_4000; jal_off_i = 20'h00002; rd_i = 5'd1; short_i = 1'b0;
    #1;
    check("R9 before edge", {31'h0, redirect_o}, 32'h0);
    @(posedge clk);
    #1;
    check("R9 after edge", target_o, 32'h0000_4004);
    #2;
    check("R9 stable", target_o, 32'h0000_4004);

    // R10 pairs: low part negative, positive, and backward displacement
    far_pair(32'h0000_1000, 32'h1234_5FF0);
    far_pair(32'h0040_0000, 32'h7654_3210);
    far_pair(32'h8000_0000, 32'hF7FF_FFFE);

    // R1 reset in mid-run clears registered outputs
    drive(2'd3, 32'h10, 32'h0, 20'h0, 12'h0, 20'h1, 5'd4, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1 mid-run wr_en", {31'h0, wr_en_o}, 32'h0);
    check("R1 mid-run wr_data", wr_data_o, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule